// File: doc/BRIEF.md
# Pipelined Single-Precision Multiply Execution Unit

This unit executes one instruction: a three-register single-precision multiply. Each cycle it may accept a 32-bit instruction word with a valid strobe. It decodes the destination and two source register indices, reads the two sources from an eight-entry file of 32-bit registers, and forms their binary32 product over two stages. The product is written to the destination one cycle after issue. The same write-back cycle may also set two sticky exception flags, one for underflow and one for overflow, in a seven-bit status register.

A small control state machine tracks whether the rounding stage holds a live operation. It has two states. **ST_IDLE** means nothing is in flight. **ST_EXEC** means a product is being rounded and will be written back at the end of the cycle. Both states go to ST_EXEC when a legal word is issued and to ST_IDLE otherwise.

The unit does not detect hazards. The single delay slot after a multiply still sees the old destination value. A preload port fills registers, and a status load port sets the whole status register, so that operand values and flag state can be placed before use.

Top module: `fmul_exec_unit`

## Requirements
- R1: A word is legal when bits 31..16 equal 0xE700 and bits 15..9 are zero. In a legal word, bits 2..0 name destination a, bits 5..3 name source b and bits 8..6 name source c. The unit writes register b times register c into register a.
- R2: A legal word sampled with `issue_valid` high at clock edge k makes `wb_strobe` high between edges k and k+1. The destination is updated at edge k+1. Registers change only at such write-backs or through the preload port.
- R3: A multiply issued in the cycle right after another multiply reads the register contents from before the first multiply's write-back. There is no stall and no forwarding, and back-to-back issues each write back.
- R4: For products in the normal range, the result equals the exact product of the operand values, rounded to nearest-even at 24 significant bits. Operands with an all-ones exponent are treated as ordinary finite values.
- R5: If either operand has a zero exponent field (zero or denormal), the result is zero with sign equal to the XOR of the operand signs, and no flag is set.
- R6: If the rounded biased exponent reaches 255 or more, the result is saturated to the signed largest finite value (magnitude 0x7F7FFFFF), and status bit 6 (overflow) is set.
- R7: If the rounded biased exponent is 0 or less, the result is a signed zero, and status bit 5 (underflow) is set.
- R8: Status bits 5 and 6 are sticky. A multiply never clears them. `flag_clear` clears both at the next edge, unless a write-back sets one in the same cycle, in which case the set wins.
- R9: Status bits 4..0 (test, integer zero, integer negative, float zero, float negative) are never changed by a multiply. Only `stat_we` changes them, and it loads all seven bits from `stat_wdata`, taking priority over set and clear.
- R10: A word that is not legal, or any word with `issue_valid` low, causes no `wb_strobe`, no register change and no flag change.
- R11: When `preload_we` is high, register `preload_idx` takes `preload_data` at the next edge.
- R12: Reset (active-low `rst_n`) clears all registers and the status register and leaves `wb_strobe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction word valid this cycle |
| instr | input | 32 | Instruction word |
| preload_we | input | 1 | Register preload enable |
| preload_idx | input | 3 | Register index to preload |
| preload_data | input | 32 | Value to preload |
| stat_we | input | 1 | Load whole status register |
| stat_wdata | input | 7 | Status value to load |
| flag_clear | input | 1 | Clear sticky underflow and overflow flags |
| wb_strobe | output | 1 | High in the cycle whose closing edge writes a result |
| status | output | 7 | Status: bit 6 overflow, bit 5 underflow, bits 4..0 other flags |
| regs_flat | output | 256 | All eight registers, register i at bits 32*i+31..32*i |

## Verification
An issue driven before edge k shows `wb_strobe` high when sampled on the falling edge after edge k. The destination register and the sticky flags change at edge k+1, so the bench reads them on the falling edge after k+1. Before that, the bench checks that the destination still holds its old value. For the delay-slot case, the second word is driven on the falling edge between the two edges of the first word. Its result is read one falling edge after the first word's result. A broad sweep compares every result and flag against a product formed in double precision and rounded to nearest-even in the bench. Directed words cover ignored encodings, flag clear colliding with a flag set, and the other five status bits.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int SIG_W    = MAN_W + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;
    localparam int ESUM_W   = EXP_W + 3;

    localparam int NREG     = 8;
    localparam int IDX_W    = $clog2(NREG);
    localparam int INSTR_W  = 32;
    localparam int HALF_W   = INSTR_W / 2;

    localparam logic [HALF_W-1:0] OPC_UPPER = 16'hE700;

    localparam int STAT_W   = 7;
    localparam int STAT_UF  = 5;
    localparam int STAT_OF  = 6;

    typedef enum logic {
        ST_IDLE,
        ST_EXEC
    } pipe_state_t;

    typedef struct packed {
        logic             legal;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] srb;
        logic [IDX_W-1:0] src;
    } dec_t;

    typedef struct packed {
        logic                     sign;
        logic                     zero;
        logic signed [ESUM_W-1:0] esum;
        logic [PROD_W-1:0]        prod;
        logic [IDX_W-1:0]         dst;
    } stage_t;
endpackage

// File: rtl/fmul_decode.sv
module fmul_decode
    import fmul_pkg::*;
(
    input  logic               issue_valid,
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam int FIELD_TOP = 3 * IDX_W;

    logic upper_ok;
    logic pad_ok;

    always_comb begin
        upper_ok  = (instr[INSTR_W-1:HALF_W] == OPC_UPPER);
        pad_ok    = (instr[HALF_W-1:FIELD_TOP] == '0);
        dec.legal = issue_valid && upper_ok && pad_ok;
        dec.dst   = instr[IDX_W-1:0];
        dec.srb   = instr[2*IDX_W-1:IDX_W];
        dec.src   = instr[FIELD_TOP-1:2*IDX_W];
    end
endmodule

// File: rtl/fmul_regfile.sv
module fmul_regfile
    import fmul_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pre_we,
    input  logic [IDX_W-1:0]     pre_idx,
    input  logic [FP_W-1:0]      pre_data,
    input  logic                 wb_we,
    input  logic [IDX_W-1:0]     wb_idx,
    input  logic [FP_W-1:0]      wb_data,
    input  logic [IDX_W-1:0]     rd_idx_b,
    input  logic [IDX_W-1:0]     rd_idx_c,
    output logic [FP_W-1:0]      rd_b,
    output logic [FP_W-1:0]      rd_c,
    output logic [NREG*FP_W-1:0] regs_flat
);
    logic [FP_W-1:0] entry_q [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[gi] <= '0;
            end else if (wb_we && (wb_idx == IDX_W'(gi))) begin
                entry_q[gi] <= wb_data;
            end else if (pre_we && (pre_idx == IDX_W'(gi))) begin
                entry_q[gi] <= pre_data;
            end
        end
        assign regs_flat[gi*FP_W +: FP_W] = entry_q[gi];
    end

    assign rd_b = entry_q[rd_idx_b];
    assign rd_c = entry_q[rd_idx_c];
endmodule

// File: rtl/fmul_mul_stage.sv
module fmul_mul_stage
    import fmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] dst,
    input  logic [FP_W-1:0]  op_b,
    input  logic [FP_W-1:0]  op_c,
    output stage_t           q
);
    localparam logic signed [ESUM_W-1:0] BIAS_X = ESUM_W'(EXP_BIAS);

    logic [EXP_W-1:0]         exp_b;
    logic [EXP_W-1:0]         exp_c;
    logic [SIG_W-1:0]         sig_b;
    logic [SIG_W-1:0]         sig_c;
    logic signed [ESUM_W-1:0] ext_b;
    logic signed [ESUM_W-1:0] ext_c;
    stage_t                   d;

    always_comb begin
        exp_b  = op_b[FP_W-2 -: EXP_W];
        exp_c  = op_c[FP_W-2 -: EXP_W];
        sig_b  = {1'b1, op_b[MAN_W-1:0]};
        sig_c  = {1'b1, op_c[MAN_W-1:0]};
        ext_b  = ESUM_W'(exp_b);
        ext_c  = ESUM_W'(exp_c);
        d.sign = op_b[FP_W-1] ^ op_c[FP_W-1];
        d.zero = (exp_b == '0) || (exp_c == '0);
        d.esum = ext_b + ext_c - BIAS_X;
        d.prod = PROD_W'(sig_b) * PROD_W'(sig_c);
        d.dst  = dst;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/fmul_round_stage.sv
module fmul_round_stage
    import fmul_pkg::*;
(
    input  logic                     sign,
    input  logic                     zero,
    input  logic signed [ESUM_W-1:0] esum,
    input  logic [PROD_W-1:0]        prod,
    output logic [FP_W-1:0]          result,
    output logic                     uf,
    output logic                     of
);
    localparam logic signed [ESUM_W-1:0] E_TOP  = ESUM_W'(EXP_MAX);
    localparam logic signed [ESUM_W-1:0] E_ZERO = '0;

    logic                     hi;
    logic [MAN_W-1:0]         frac;
    logic                     guard;
    logic                     sticky;
    logic                     rnd_up;
    logic [MAN_W:0]           frac_sum;
    logic signed [ESUM_W-1:0] exp_fin;

    always_comb begin
        hi = prod[PROD_W-1];
        if (hi) begin
            frac   = prod[PROD_W-2 -: MAN_W];
            guard  = prod[PROD_W-2-MAN_W];
            sticky = |prod[PROD_W-3-MAN_W:0];
        end else begin
            frac   = prod[PROD_W-3 -: MAN_W];
            guard  = prod[PROD_W-3-MAN_W];
            sticky = |prod[PROD_W-4-MAN_W:0];
        end
        rnd_up   = guard && (sticky || frac[0]);
        frac_sum = {1'b0, frac} + (MAN_W+1)'(rnd_up);
        exp_fin  = esum + ESUM_W'(hi) + ESUM_W'(frac_sum[MAN_W]);

        of = !zero && (exp_fin >= E_TOP);
        uf = !zero && (exp_fin <= E_ZERO);

        if (zero || uf) begin
            result = {sign, {(FP_W-1){1'b0}}};
        end else if (of) begin
            result = {sign, EXP_W'(EXP_MAX - 1), {MAN_W{1'b1}}};
        end else begin
            result = {sign, exp_fin[EXP_W-1:0], frac_sum[MAN_W-1:0]};
        end
    end
endmodule

// File: rtl/fmul_exec_unit.sv
module fmul_exec_unit
    import fmul_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic                 preload_we,
    input  logic [IDX_W-1:0]     preload_idx,
    input  logic [FP_W-1:0]      preload_data,
    input  logic                 stat_we,
    input  logic [STAT_W-1:0]    stat_wdata,
    input  logic                 flag_clear,
    output logic                 wb_strobe,
    output logic [STAT_W-1:0]    status,
    output logic [NREG*FP_W-1:0] regs_flat
);
    dec_t              dec;
    logic              accept;
    logic [FP_W-1:0]   rd_b;
    logic [FP_W-1:0]   rd_c;
    stage_t            stg;
    logic [FP_W-1:0]   res;
    logic              res_uf;
    logic              res_of;
    pipe_state_t       st_q;
    pipe_state_t       st_d;
    logic [STAT_W-1:0] stat_q;

    fmul_decode u_dec (
        .issue_valid (issue_valid),
        .instr       (instr),
        .dec         (dec)
    );

    assign accept = dec.legal;

    fmul_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_we    (preload_we),
        .pre_idx   (preload_idx),
        .pre_data  (preload_data),
        .wb_we     (wb_strobe),
        .wb_idx    (stg.dst),
        .wb_data   (res),
        .rd_idx_b  (dec.srb),
        .rd_idx_c  (dec.src),
        .rd_b      (rd_b),
        .rd_c      (rd_c),
        .regs_flat (regs_flat)
    );

    fmul_mul_stage u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .dst   (dec.dst),
        .op_b  (rd_b),
        .op_c  (rd_c),
        .q     (stg)
    );

    fmul_round_stage u_rnd (
        .sign   (stg.sign),
        .zero   (stg.zero),
        .esum   (stg.esum),
        .prod   (stg.prod),
        .result (res),
        .uf     (res_uf),
        .of     (res_of)
    );

    // Control state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic: the rounding stage is live only after a legal issue
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = accept ? ST_EXEC : ST_IDLE;
            ST_EXEC: st_d = accept ? ST_EXEC : ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (st_q)
            ST_IDLE: wb_strobe = 1'b0;
            ST_EXEC: wb_strobe = 1'b1;
        endcase
    end

    // Status: full load wins, then sticky set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (stat_we) begin
            stat_q <= stat_wdata;
        end else begin
            if (flag_clear) begin
                stat_q[STAT_UF] <= 1'b0;
                stat_q[STAT_OF] <= 1'b0;
            end
            if (wb_strobe && res_uf) begin
                stat_q[STAT_UF] <= 1'b1;
            end
            if (wb_strobe && res_of) begin
                stat_q[STAT_OF] <= 1'b1;
            end
        end
    end

    assign status = stat_q;
endmodule

// File: rtl/fmul_exec_unit_chk.sv
module fmul_exec_unit_chk
    import fmul_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic [INSTR_W-1:0]   instr,
    input logic                 preload_we,
    input logic                 stat_we,
    input logic                 flag_clear,
    input logic                 wb_strobe,
    input logic [STAT_W-1:0]    status,
    input logic [NREG*FP_W-1:0] regs_flat
);
    logic legal_word;
    assign legal_word = issue_valid && (instr[31:16] == 16'hE700) && (instr[15:9] == 7'd0);

    assert_wb_follows_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_strobe |-> $past(legal_word));

    assert_ignored_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_word |=> !wb_strobe);

    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wb_strobe) && !$past(preload_we)) |-> (regs_flat == $past(regs_flat)));

    assert_sticky_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status[STAT_OF]) && !$past(flag_clear) && !$past(stat_we)) |-> status[STAT_OF]);

    assert_other_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_we) |-> (status[4:0] == $past(status[4:0])));

    assert_overflow_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[STAT_OF]) |-> ($past(wb_strobe) || $past(stat_we)));

    assert_underflow_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[STAT_UF]) |-> ($past(wb_strobe) || $past(stat_we)));
endmodule

bind fmul_exec_unit fmul_exec_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .instr       (instr),
    .preload_we  (preload_we),
    .stat_we     (stat_we),
    .flag_clear  (flag_clear),
    .wb_strobe   (wb_strobe),
    .status      (status),
    .regs_flat   (regs_flat)
);

// File: tb/fmul_exec_unit_tb_top.sv
module fmul_exec_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic         preload_we = 1'b0;
    logic [2:0]   preload_idx = '0;
    logic [31:0]  preload_data = '0;
    logic         stat_we = 1'b0;
    logic [6:0]   stat_wdata = '0;
    logic         flag_clear = 1'b0;
    logic         wb_strobe;
    logic [6:0]   status;
    logic [255:0] regs_flat;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fmul_exec_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .instr        (instr),
        .preload_we   (preload_we),
        .preload_idx  (preload_idx),
        .preload_data (preload_data),
        .stat_we      (stat_we),
        .stat_wdata   (stat_wdata),
        .flag_clear   (flag_clear),
        .wb_strobe    (wb_strobe),
        .status       (status),
        .regs_flat    (regs_flat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input int idx);
        return regs_flat[idx*32 +: 32];
    endfunction

    function automatic logic [31:0] word(input int a, input int b, input int c);
        return {16'hE700, 7'd0, 3'(c), 3'(b), 3'(a)};
    endfunction

    // Reference: exact product in double precision, rounded to nearest-even at 24 bits.
    // Returns {overflow, underflow, result}.
    function automatic logic [33:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
        logic        s;
        logic [63:0] dx;
        logic [63:0] dy;
        logic [63:0] dp;
        logic [22:0] keep;
        logic [28:0] rem;
        logic        up;
        logic [23:0] ks;
        int          fe;
        s = x[31] ^ y[31];
        if (x[30:23] == 8'd0 || y[30:23] == 8'd0) return {2'b00, s, 31'd0};
        dx = {1'b0, 11'(x[30:23]) + 11'd896, x[22:0], 29'd0};
        dy = {1'b0, 11'(y[30:23]) + 11'd896, y[22:0], 29'd0};
        dp = $realtobits($bitstoreal(dx) * $bitstoreal(dy));
        keep = dp[51:29];
        rem  = dp[28:0];
        up   = rem[28] & ((|rem[27:0]) | keep[0]);
        ks   = {1'b0, keep} + 24'(up);
        fe   = int'(dp[62:52]) - 896 + (ks[23] ? 1 : 0);
        if (fe >= 255) return {2'b10, s, 31'h7F7FFFFF};
        if (fe <= 0)   return {2'b01, s, 31'd0};
        return {2'b00, s, fe[7:0], ks[22:0]};
    endfunction

    function automatic logic [31:0] mk_val();
        logic [31:0] r;
        int          sel;
        logic [7:0]  e;
        r   = $urandom;
        sel = $urandom % 4;
        if (sel == 0)      e = 8'(190 + ($urandom % 66));
        else if (sel == 1) e = 8'($urandom % 64);
        else               e = 8'($urandom);
        return {r[31], e, r[22:0]};
    endfunction

    task automatic preload(input int idx, input logic [31:0] v);
        preload_we = 1'b1;
        preload_idx = 3'(idx);
        preload_data = v;
        @(negedge clk);
        preload_we = 1'b0;
    endtask

    task automatic pulse_clear();
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
    endtask

    // Issue at a falling edge, return after the write-back edge
    task automatic run_mul(input int a, input int b, input int c, input logic [31:0] old_a);
        instr = word(a, b, c);
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R2 strobe in write cycle", 32'(wb_strobe), 32'd1);
        chk("R2 destination not yet written", rd(a), old_a);
        @(negedge clk);
        chk("R2 strobe low after write", 32'(wb_strobe), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [33:0] exp;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        for (int i = 0; i < 8; i++) chk("R12 register cleared", rd(i), 32'd0);
        chk("R12 status cleared", 32'(status), 32'd0);
        chk("R12 strobe low", 32'(wb_strobe), 32'd0);

        // R11 preload, R1/R2 basic multiply 1.5 * 2.0
        preload(1, 32'h3FC00000);
        preload(2, 32'h40000000);
        chk("R11 preload r1", rd(1), 32'h3FC00000);
        run_mul(3, 1, 2, 32'd0);
        chk("R1 r3 = r1*r2", rd(3), 32'h40400000);

        // R3 delay slot reads old value, back-to-back both write
        preload(1, 32'h40000000);
        preload(2, 32'h40400000);
        instr = word(2, 1, 2);
        issue_valid = 1'b1;
        @(negedge clk);
        chk("R3 first strobe", 32'(wb_strobe), 32'd1);
        instr = word(3, 2, 1);
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R3 second strobe", 32'(wb_strobe), 32'd1);
        chk("R3 first result", rd(2), 32'h40C00000);
        @(negedge clk);
        chk("R3 delay slot used old source", rd(3), 32'h40C00000);

        // R4 rounding ties and carry into exponent
        preload(4, 32'h3F800001);
        preload(5, 32'h3FC00000);
        run_mul(6, 4, 5, rd(6));
        chk("R4 tie rounds to even", rd(6), 32'h3FC00002);
        exp = ref_mul(32'h3FFFFFFF, 32'h3F800001);
        preload(4, 32'h3FFFFFFF);
        preload(5, 32'h3F800001);
        run_mul(6, 4, 5, rd(6));
        chk("R4 carry case", rd(6), exp[31:0]);

        // R5 zero and denormal operands
        preload(1, 32'h80000000);
        preload(2, 32'h40A00000);
        run_mul(3, 1, 2, rd(3));
        chk("R5 -0 * 5", rd(3), 32'h80000000);
        preload(1, 32'h00000001);
        preload(2, 32'hC0400000);
        run_mul(3, 1, 2, rd(3));
        chk("R5 denormal * -3", rd(3), 32'h80000000);
        chk("R5 no flags", 32'(status), 32'd0);

        // R6 overflow saturates
        preload(1, 32'h7F000000);
        preload(2, 32'hC0800000);
        run_mul(3, 1, 2, rd(3));
        chk("R6 saturated negative", rd(3), 32'hFF7FFFFF);
        chk("R6 overflow flag", 32'(status), 32'h40);

        // R8 sticky through a clean multiply, then clear
        preload(2, 32'h40000000);
        preload(4, 32'h40400000);
        run_mul(5, 2, 4, rd(5));
        chk("R8 flag stays set", 32'(status), 32'h40);
        pulse_clear();
        chk("R8 clear", 32'(status), 32'd0);

        // R7 underflow to signed zero
        preload(1, 32'h00800000);
        preload(2, 32'hBF000000);
        run_mul(3, 1, 2, 32'hFF7FFFFF);
        chk("R7 signed zero", rd(3), 32'h80000000);
        chk("R7 underflow flag", 32'(status), 32'h20);
        pulse_clear();

        // R8 set beats clear in the same cycle
        preload(1, 32'h7F000000);
        preload(2, 32'h40800000);
        instr = word(3, 1, 2);
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
        chk("R8 set wins over clear", 32'(status), 32'h40);
        chk("R6 positive saturation", rd(3), 32'h7F7FFFFF);

        // R9 other flags untouched by multiply
        stat_we = 1'b1;
        stat_wdata = 7'h1F;
        @(negedge clk);
        stat_we = 1'b0;
        chk("R9 status load", 32'(status), 32'h1F);
        run_mul(3, 1, 2, 32'h7F7FFFFF);
        chk("R9 low flags kept, overflow set", 32'(status), 32'h5F);
        stat_we = 1'b1;
        stat_wdata = 7'h00;
        @(negedge clk);
        stat_we = 1'b0;

        // R10 ignored words: bad upper half, nonzero pad bit, valid low
        preload(4, 32'h7F000000);
        preload(3, 32'h7F000000);
        preload(5, 32'h12345678);
        for (int k = 0; k < 3; k++) begin
            if (k == 0) instr = {16'hE701, 7'd0, 3'd3, 3'd4, 3'd5};
            else if (k == 1) instr = {16'hE700, 7'd1, 3'd3, 3'd4, 3'd5};
            else instr = word(5, 4, 3);
            issue_valid = (k != 2);
            @(negedge clk);
            issue_valid = 1'b0;
            chk("R10 no strobe", 32'(wb_strobe), 32'd0);
            @(negedge clk);
            chk("R10 destination unchanged", rd(5), 32'h12345678);
            chk("R10 flags unchanged", 32'(status), 32'd0);
        end

        // R1/R4/R6/R7 sweep against the reference
        for (int t = 0; t < 2500; t++) begin
            int a;
            int b;
            int c;
            logic [31:0] va;
            logic [31:0] vb;
            logic [31:0] ob;
            a  = int'($urandom % 8);
            b  = int'($urandom % 8);
            c  = int'($urandom % 8);
            va = mk_val();
            vb = mk_val();
            pulse_clear();
            preload(b, va);
            preload(c, vb);
            ob  = (b == c) ? vb : va;
            exp = ref_mul(ob, vb);
            run_mul(a, b, c, rd(a));
            chk("R1 R4 sweep result", rd(a), exp[31:0]);
            chk("R6 sweep overflow flag", 32'(status[6]), 32'(exp[33]));
            chk("R7 sweep underflow flag", 32'(status[5]), 32'(exp[32]));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule